// File: doc/BRIEF.md
# Deferred Coherence Invalidation Controller

This block is the coherence-side logic of one processor cache under a release-consistent memory model. It decides when invalidations leave the processor and when invalidations that arrive are applied to the cache. It supports four timing modes. In the on-the-fly mode everything happens at once. In the other modes work is deferred to a synchronization point: the send side, the receive side, or both.

On the send side, a store to a block the processor does not own can be held in a small store buffer. Stores to a block that is already buffered are merged, so a single outgoing invalidation covers all of them. A release drains the buffer at one invalidation per cycle, and a busy flag stays high for the whole drain. On the receive side, an incoming invalidation can be noted in a per-block stale bit. The next acquire then clears, in one cycle, the valid bit of every stale block. A fill input marks a block valid again once its miss has been served. Data values, directory state and the network lie outside this block.

Top module: `dly_inval_ctrl`

## Requirements
- R1: After reset every block valid bit is low, the store buffer is empty, `busy` is low, `invOutValid` is low and `storeStall` is low.
- R2: `modeSel` bit 0 enables receive-side delay and bit 1 enables send-side delay. The values are 0 on-the-fly, 1 receive-delayed, 2 send-delayed and 3 both.
- R3: While send-side delay is off and `busy` is low, a store to a non-owned block raises `invOutValid` in the next cycle with `invOutBlk` equal to the stored block. A store to an owned block never produces an outgoing invalidation, in any mode.
- R4: While send-side delay is on, a store to a non-owned block produces no outgoing invalidation when it is issued. A store to a block that is already buffered is merged and takes no new buffer entry.
- R5: A release while send-side delay is on and the buffer holds N distinct blocks raises `busy` in the next cycle. It then presents one invalidation per cycle for N cycles, in the order in which each block was first buffered, and `busy` is low after that. A release with an empty buffer, or with send-side delay off, has no effect.
- R6: With send-side delay on and the buffer full, a non-owned store to a block not in the buffer raises `storeStall` in the same cycle and is not taken. A store to a block already buffered, or to an owned block, is not stalled.
- R7: While `busy` is high, every non-owned store is stalled and is not taken.
- R8: With receive-side delay off, an incoming invalidation clears that block's valid bit in the next cycle.
- R9: With receive-side delay on, an incoming invalidation leaves the valid bits unchanged and marks the block stale. An acquire clears, in the next cycle, the valid bit of every stale block and clears all stale marks.
- R10: A fill sets the block's valid bit in the next cycle and removes any stale mark it has, so a later acquire leaves it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Timing mode: bit 0 receive delay, bit 1 send delay |
| storeValid | input | 1 | Local store strobe |
| storeBlk | input | BLK_W | Block index of the store |
| storeOwned | input | 1 | Processor owns the stored block |
| storeStall | output | 1 | Store cannot be taken this cycle |
| releaseReq | input | 1 | Release strobe |
| acquireReq | input | 1 | Acquire strobe |
| invInValid | input | 1 | Incoming invalidation strobe |
| invInBlk | input | BLK_W | Block index of the incoming invalidation |
| fillValid | input | 1 | Miss fill completed |
| fillBlk | input | BLK_W | Block index of the fill |
| invOutValid | output | 1 | Outgoing invalidation present |
| invOutBlk | output | BLK_W | Block index of the outgoing invalidation |
| busy | output | 1 | Store buffer drain in progress |
| blkValid | output | NUM_BLOCKS | Per-block valid bits |

## Verification
The receive path is swept over every mode and every block index: one invalidation, then an acquire, then a refill. The bench compares the full valid vector each time, so a wrong bit position, a wrong mode decode or an acquire that clears too much stands out. The send path is driven with an immediate-mode sweep over all blocks and with a repeated-block sequence whose drain must show each block once in first-store order. A fill-to-capacity sequence then separates a merge hit from a full stall and from an owned-store bypass. Releases with an empty buffer or in a mode without send delay, and stores issued during a drain, check that the deferred path starts and stops only when it should.

// File: rtl/dly_inval_pkg.sv
package dly_inval_pkg;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic push;        // add the store block to the buffer
    logic pop;         // drop the head entry, head is on the output
    logic pass;        // capture the store block for immediate send
    logic applyStale;  // acquire: invalidate all stale blocks
    logic markStale;   // record the incoming block as stale
    logic dropNow;     // invalidate the incoming block at once
  } ctlStrobes_t;

  // Status from the datapath back to the control.
  typedef struct packed {
    logic hit;    // store block already buffered
    logic full;
    logic empty;
    logic last;   // exactly one entry left
  } sbStatus_t;

endpackage

// File: rtl/dly_inval_dp.sv
module dly_inval_dp
  import dly_inval_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int SB_DEPTH   = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(SB_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [BLK_W-1:0]      storeBlk,
  input  logic [BLK_W-1:0]      invInBlk,
  input  logic                  fillValid,
  input  logic [BLK_W-1:0]      fillBlk,
  output sbStatus_t             status,
  output logic [BLK_W-1:0]      outBlk,
  output logic [NUM_BLOCKS-1:0] blkValid
);

  logic [BLK_W-1:0]      sbEntry [SB_DEPTH];
  logic [CNT_W-1:0]      sbCount;
  logic [BLK_W-1:0]      passBlk;
  logic [NUM_BLOCKS-1:0] validQ, staleQ, validD, staleD;

  // Buffer status
  always_comb begin
    status.hit = 1'b0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      if (CNT_W'(i) < sbCount && sbEntry[i] == storeBlk) status.hit = 1'b1;
    end
    status.full  = (sbCount == CNT_W'(SB_DEPTH));
    status.empty = (sbCount == '0);
    status.last  = (sbCount == CNT_W'(1));
  end

  // Store buffer: append at the tail, shift out at the head
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbCount <= '0;
      passBlk <= '0;
      for (int i = 0; i < SB_DEPTH; i++) sbEntry[i] <= '0;
    end else begin
      if (strobes.pass) passBlk <= storeBlk;
      if (strobes.push) begin
        for (int i = 0; i < SB_DEPTH; i++) begin
          if (sbCount == CNT_W'(i)) sbEntry[i] <= storeBlk;
        end
        sbCount <= sbCount + CNT_W'(1);
      end else if (strobes.pop) begin
        for (int i = 0; i < SB_DEPTH - 1; i++) sbEntry[i] <= sbEntry[i+1];
        sbEntry[SB_DEPTH-1] <= '0;
        sbCount <= sbCount - CNT_W'(1);
      end
    end
  end

  assign outBlk = strobes.pop ? sbEntry[0] : passBlk;

  // Valid and stale bits. Acquire first, then fill, then the new arrival.
  always_comb begin
    validD = validQ;
    staleD = staleQ;
    if (strobes.applyStale) begin
      validD = validQ & ~staleQ;
      staleD = '0;
    end
    if (fillValid) begin
      validD[fillBlk] = 1'b1;
      staleD[fillBlk] = 1'b0;
    end
    if (strobes.markStale) staleD[invInBlk] = 1'b1;
    if (strobes.dropNow)   validD[invInBlk] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      staleQ <= '0;
    end else begin
      validQ <= validD;
      staleQ <= staleD;
    end
  end

  assign blkValid = validQ;

endmodule

// File: rtl/dly_inval_ctl.sv
module dly_inval_ctl
  import dly_inval_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        storeValid,
  input  logic        storeOwned,
  input  logic        releaseReq,
  input  logic        acquireReq,
  input  logic        invInValid,
  input  sbStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        storeStall,
  output logic        draining,
  output logic        passValid
);

  logic recvDelay, sendDelay, needInv, startDrain;

  assign recvDelay = modeSel[0];
  assign sendDelay = modeSel[1];
  assign needInv   = storeValid & ~storeOwned;

  assign storeStall = needInv & (draining | (sendDelay & status.full & ~status.hit));

  always_comb begin
    strobes            = '0;
    strobes.push       = needInv & sendDelay & ~draining & ~status.hit & ~status.full;
    strobes.pass       = needInv & ~sendDelay & ~draining;
    strobes.pop        = draining;
    strobes.applyStale = acquireReq;
    strobes.markStale  = invInValid & recvDelay;
    strobes.dropNow    = invInValid & ~recvDelay;
  end

  assign startDrain = releaseReq & sendDelay & ~draining & (~status.empty | strobes.push);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      draining  <= 1'b0;
      passValid <= 1'b0;
    end else begin
      passValid <= strobes.pass;
      if (draining) begin
        if (status.last) draining <= 1'b0;
      end else if (startDrain) begin
        draining <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dly_inval_ctrl.sv
module dly_inval_ctrl
  import dly_inval_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int SB_DEPTH   = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            modeSel,
  input  logic                  storeValid,
  input  logic [BLK_W-1:0]      storeBlk,
  input  logic                  storeOwned,
  output logic                  storeStall,
  input  logic                  releaseReq,
  input  logic                  acquireReq,
  input  logic                  invInValid,
  input  logic [BLK_W-1:0]      invInBlk,
  input  logic                  fillValid,
  input  logic [BLK_W-1:0]      fillBlk,
  output logic                  invOutValid,
  output logic [BLK_W-1:0]      invOutBlk,
  output logic                  busy,
  output logic [NUM_BLOCKS-1:0] blkValid
);

  ctlStrobes_t strobes;
  sbStatus_t   status;
  logic        draining, passValid;

  dly_inval_ctl ctl_i (
    .clk, .rstN, .modeSel, .storeValid, .storeOwned, .releaseReq,
    .acquireReq, .invInValid, .status, .strobes, .storeStall,
    .draining, .passValid
  );

  dly_inval_dp #(.NUM_BLOCKS(NUM_BLOCKS), .SB_DEPTH(SB_DEPTH)) dp_i (
    .clk, .rstN, .strobes, .storeBlk, .invInBlk, .fillValid, .fillBlk,
    .status, .outBlk(invOutBlk), .blkValid
  );

  assign invOutValid = draining | passValid;
  assign busy        = draining;

endmodule

// File: rtl/dly_inval_ctrl_chk.sv
module dly_inval_ctrl_chk #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            modeSel,
  input logic                  storeValid,
  input logic [BLK_W-1:0]      storeBlk,
  input logic                  storeOwned,
  input logic                  storeStall,
  input logic                  acquireReq,
  input logic                  invInValid,
  input logic [BLK_W-1:0]      invInBlk,
  input logic                  fillValid,
  input logic                  invOutValid,
  input logic [BLK_W-1:0]      invOutBlk,
  input logic                  busy,
  input logic [NUM_BLOCKS-1:0] blkValid
);

  a_r3_owned_silent: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeOwned && !busy && !modeSel[1]) |=> !invOutValid);

  a_r3_immediate_send: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !storeOwned && !busy && !modeSel[1])
      |=> (invOutValid && invOutBlk == $past(storeBlk)));

  a_r5_busy_sends: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> invOutValid);

  a_r6_stall_only_nonowned: assert property (@(posedge clk) disable iff (!rstN)
    storeStall |-> (storeValid && !storeOwned));

  a_r7_stall_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && storeValid && !storeOwned) |-> storeStall);

  a_r8_drop_now: assert property (@(posedge clk) disable iff (!rstN)
    (invInValid && !modeSel[0]) |=> !blkValid[$past(invInBlk)]);

  a_r9_defer_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (invInValid && modeSel[0] && !acquireReq && !fillValid) |=> blkValid == $past(blkValid));

  a_r9_acquire_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (acquireReq && !fillValid) |=> (blkValid & ~$past(blkValid)) == '0);

endmodule

bind dly_inval_ctrl dly_inval_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .storeValid(storeValid),
  .storeBlk(storeBlk), .storeOwned(storeOwned), .storeStall(storeStall),
  .acquireReq(acquireReq), .invInValid(invInValid), .invInBlk(invInBlk),
  .fillValid(fillValid), .invOutValid(invOutValid), .invOutBlk(invOutBlk),
  .busy(busy), .blkValid(blkValid)
);

// File: tb/dly_inval_ctrl_tb_top.sv
`timescale 1ns/1ps
module dly_inval_ctrl_tb_top;

  localparam int NB = 8;
  localparam int SD = 4;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    modeSel;
  logic          storeValid, storeOwned, releaseReq, acquireReq;
  logic          invInValid, fillValid;
  logic [BW-1:0] storeBlk, invInBlk, fillBlk;
  logic          storeStall, invOutValid, busy;
  logic [BW-1:0] invOutBlk;
  logic [NB-1:0] blkValid;

  int nTests = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  dly_inval_ctrl #(.NUM_BLOCKS(NB), .SB_DEPTH(SD)) dut_i (
    .clk, .rstN, .modeSel, .storeValid, .storeBlk, .storeOwned, .storeStall,
    .releaseReq, .acquireReq, .invInValid, .invInBlk, .fillValid, .fillBlk,
    .invOutValid, .invOutBlk, .busy, .blkValid
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic clearIn();
    storeValid = 0; storeOwned = 0; releaseReq = 0; acquireReq = 0;
    invInValid = 0; fillValid = 0;
  endtask

  task automatic store(input int blk, input logic owned);
    storeValid = 1; storeBlk = BW'(blk); storeOwned = owned;
    tick();
    storeValid = 0; storeOwned = 0;
  endtask

  task automatic fill(input int blk);
    fillValid = 1; fillBlk = BW'(blk);
    tick();
    fillValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    rstN = 0; modeSel = 0; storeBlk = 0; invInBlk = 0; fillBlk = 0;
    clearIn();
    repeat (3) tick();
    rstN = 1;
    settle();
    check("R1 valid", 32'(blkValid), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 out", 32'(invOutValid), 0);
    check("R1 stall", 32'(storeStall), 0);

    for (int b = 0; b < NB; b++) fill(b);
    check("R10 fill all", 32'(blkValid), 32'((1 << NB) - 1));

    // Receive sweep over all modes and blocks (R2, R8, R9, R10)
    for (int m = 0; m < 4; m++) begin
      modeSel = 2'(m);
      for (int b = 0; b < NB; b++) begin
        logic [NB-1:0] full, less;
        full = '1;
        less = full & ~(NB'(1) << b);
        invInValid = 1; invInBlk = BW'(b);
        tick();
        invInValid = 0;
        if (m[0]) check("R9 R2 deferred inv", 32'(blkValid), 32'(full));
        else      check("R8 R2 immediate inv", 32'(blkValid), 32'(less));
        acquireReq = 1;
        tick();
        acquireReq = 0;
        check("R9 acquire applies", 32'(blkValid), 32'(less));
        fill(b);
        check("R10 refill", 32'(blkValid), 32'(full));
      end
    end

    // Fill clears a stale mark (R10)
    modeSel = 2'd1;
    invInValid = 1; invInBlk = 3'd2;
    tick();
    invInValid = 0;
    fill(2);
    acquireReq = 1;
    tick();
    acquireReq = 0;
    check("R10 fill clears stale", 32'(blkValid), 32'hFF);

    // Immediate send sweep (R3)
    for (int m = 0; m < 2; m++) begin
      modeSel = 2'(m);
      for (int b = 0; b < NB; b++) begin
        storeValid = 1; storeBlk = BW'(b); storeOwned = 0;
        settle();
        check("R3 no stall", 32'(storeStall), 0);
        tick();
        storeValid = 0;
        check("R3 out valid", 32'(invOutValid), 1);
        check("R3 out blk", 32'(invOutBlk), 32'(b));
        store(b, 1'b1);
        check("R3 owned silent", 32'(invOutValid), 0);
      end
    end

    // Release ignored without send delay (R5)
    modeSel = 2'd0;
    releaseReq = 1;
    tick();
    releaseReq = 0;
    check("R5 release ignored mode0", 32'(busy), 0);

    // Send-delayed sequence with merge (R4, R5, R7)
    modeSel = 2'd2;
    releaseReq = 1;
    tick();
    releaseReq = 0;
    check("R5 empty release", 32'(busy), 0);
    store(1, 1'b1);
    check("R3 owned silent SD", 32'(invOutValid), 0);
    store(3, 1'b0);
    check("R4 buffered silent", 32'(invOutValid), 0);
    store(5, 1'b0);
    store(3, 1'b0);
    store(6, 1'b0);
    check("R4 buffered silent 2", 32'(invOutValid), 0);
    check("R4 not busy", 32'(busy), 0);
    releaseReq = 1;
    tick();
    releaseReq = 0;
    check("R5 busy on", 32'(busy), 1);
    check("R5 first out", 32'(invOutBlk), 3);
    storeValid = 1; storeBlk = 3'd7; storeOwned = 0;
    settle();
    check("R7 stall busy", 32'(storeStall), 1);
    storeOwned = 1;
    settle();
    check("R7 owned no stall", 32'(storeStall), 0);
    storeValid = 0; storeOwned = 0;
    tick();
    check("R5 second out", 32'(invOutBlk), 5);
    tick();
    check("R5 third out", 32'(invOutBlk), 6);
    check("R5 busy still", 32'(busy), 1);
    tick();
    check("R4 merge busy off", 32'(busy), 0);
    check("R5 out idle", 32'(invOutValid), 0);

    // Full buffer in combined mode (R6, R5)
    modeSel = 2'd3;
    for (int b = 0; b < SD; b++) store(b, 1'b0);
    storeValid = 1; storeBlk = BW'(SD); storeOwned = 0;
    settle();
    check("R6 full stall", 32'(storeStall), 1);
    storeBlk = 3'd2;
    settle();
    check("R6 hit no stall", 32'(storeStall), 0);
    storeBlk = BW'(SD); storeOwned = 1;
    settle();
    check("R6 owned no stall", 32'(storeStall), 0);
    tick();
    storeValid = 0; storeOwned = 0;
    releaseReq = 1;
    tick();
    releaseReq = 0;
    for (int b = 0; b < SD; b++) begin
      check("R5 full drain busy", 32'(busy), 1);
      check("R5 full drain order", 32'(invOutBlk), 32'(b));
      tick();
    end
    check("R6 stalled not taken", 32'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule